// File: doc/BRIEF.md
# Encoder Input Glitch Filter

This block sits between the three pins of a rotary or linear encoder (two phase tracks and an index track) and the decoder behind it. Each pin is first brought into the core clock domain by a short flop chain. A per-pin run-length counter then stops short spikes from reaching the decoder. A level is passed on only after the synchronised pin has shown that level for a run of cycles. The length of that run is the programmed limit plus two.

A single enable input selects filtering. With the enable low, the synchronised pins go straight to the outputs. The limit is a 21-bit field by default. The block samples it only while filtering is off, so a value written while the filter is running has no effect until the next disable.

After reset, the outputs take whatever level the pins show, with no filter delay. This means the decoder never sees a made-up edge at start-up.

Top module: `enc_spike_filter`

## Requirements
- R1: With filt_en_i low (after warm-up), each clean_o bit equals the matching raw_i bit delayed by exactly SYNC_STAGES clock edges, so a one-cycle pulse passes unchanged.
- R2: With filtering on and limit L, a new level on a raw_i bit held for at least L+2 cycles appears on clean_o at the (L+4)-th rising edge after the change, one edge later than the previous level remained.
- R3: With filtering on and limit L, a pulse of L+1 cycles or fewer leaves that clean_o bit unchanged, including at the largest limit the field allows.
- R4: The channels are filtered independently: raw_i[0] (phase A), raw_i[1] (phase B) and raw_i[2] (index) each have their own counter, and activity on one does not delay or pass another.
- R5: The run count restarts whenever the synchronised input returns to the current output level, so repeated short pulses separated by one-cycle gaps never pass.
- R6: While rst_ni is low, clean_o is all zeros. After release, clean_o shows the level present on raw_i after SYNC_STAGES edges and keeps it, without the filter delay.
- R7: Changing filt_en_i while the inputs are steady produces no change on clean_o.
- R8: The limit is taken from max_cnt_i only while filtering is off (or during warm-up). Changes to max_cnt_i while filt_en_i is high have no effect on the accepted pulse length.
- R9: A limit of 0 gives the shortest filter: a one-cycle pulse is rejected and a two-cycle pulse is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| raw_i | input | NUM_CH | Asynchronous encoder pins: bit 0 phase A, bit 1 phase B, bit 2 index |
| filt_en_i | input | 1 | High selects filtering, low bypasses it |
| max_cnt_i | input | CNT_W | Filter limit; accepted run length is this value plus two |
| clean_o | output | NUM_CH | Filtered (or bypassed) levels for the decoder |

## Verification
The bench builds the block with CNT_W reduced to 8, keeping three channels and a two-stage synchroniser. This makes the all-ones limit of 255 cheap to reach. At that limit, a 256-cycle pulse must still be rejected and a 257-cycle level accepted. This exercises the extra counter bit needed to count to the limit plus one. The narrow field also keeps limits 0 and 5 quick enough that short pulses, pulse trains and capture of the limit while disabled can all be checked at their exact edges.

// File: rtl/enc_flt_pkg.sv
package enc_flt_pkg;
  localparam int unsigned FLT_CH_DEF    = 3;
  localparam int unsigned FLT_CNT_W_DEF = 21;
  localparam int unsigned FLT_SYNC_DEF  = 2;
endpackage

// File: rtl/enc_flt_sync.sv
module enc_flt_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/enc_flt_warmup.sv
module enc_flt_warmup #(
  parameter int unsigned DEPTH = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic done_o
);
  localparam int unsigned W = $clog2(DEPTH + 1);
  logic [W-1:0] cnt_q;

  assign done_o = (cnt_q == W'(DEPTH));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!done_o) cnt_q <= cnt_q + W'(1);
  end
endmodule

// File: rtl/enc_flt_lane.sv
module enc_flt_lane #(
  parameter int unsigned CNT_W = 21
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_i,
  input  logic             en_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] lim_i,
  output logic             q_o
);
  // one extra bit: the run must reach limit + 1 before the flip edge
  localparam int unsigned CW1 = CNT_W + 1;

  logic [CW1-1:0] run_q;
  logic [CW1-1:0] run_end;
  logic           lvl_q;

  assign run_end = {1'b0, lim_i} + CW1'(1);
  assign q_o     = lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= 1'b0;
      run_q <= '0;
    end else if (load_i || !en_i) begin
      lvl_q <= in_i;
      run_q <= '0;
    end else if (in_i == lvl_q) begin
      run_q <= '0;
    end else if (run_q == run_end) begin
      lvl_q <= in_i;
      run_q <= '0;
    end else begin
      run_q <= run_q + CW1'(1);
    end
  end
endmodule

// File: rtl/enc_spike_filter.sv
module enc_spike_filter
  import enc_flt_pkg::*;
#(
  parameter int unsigned NUM_CH      = FLT_CH_DEF,
  parameter int unsigned CNT_W       = FLT_CNT_W_DEF,
  parameter int unsigned SYNC_STAGES = FLT_SYNC_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] raw_i,
  input  logic              filt_en_i,
  input  logic [CNT_W-1:0]  max_cnt_i,
  output logic [NUM_CH-1:0] clean_o
);
  localparam int unsigned WARM_EDGES = SYNC_STAGES + 1;

  logic              warm_done;
  logic [CNT_W-1:0]  lim_q;
  logic [NUM_CH-1:0] sync_q;
  logic [NUM_CH-1:0] lane_q;

  enc_flt_warmup #(.DEPTH(WARM_EDGES)) u_warm (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .done_o(warm_done)
  );

  // limit is frozen while the filter runs
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       lim_q <= '0;
    else if (!warm_done || !filt_en_i) lim_q <= max_cnt_i;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    enc_flt_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (raw_i[c]),
      .q_o   (sync_q[c])
    );

    enc_flt_lane #(.CNT_W(CNT_W)) u_lane (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .in_i  (sync_q[c]),
      .en_i  (filt_en_i),
      .load_i(!warm_done),
      .lim_i (lim_q),
      .q_o   (lane_q[c])
    );
  end

  assign clean_o = (filt_en_i && warm_done) ? lane_q : sync_q;
endmodule

// File: rtl/enc_flt_chk.sv
module enc_flt_chk #(
  parameter int unsigned NUM_CH      = 3,
  parameter int unsigned CNT_W       = 21,
  parameter int unsigned SYNC_STAGES = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NUM_CH-1:0] raw_i,
  input logic              filt_en_i,
  input logic [NUM_CH-1:0] clean_o,
  input logic [CNT_W-1:0]  lim_i
);
  logic [3:0] seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              seen_q <= '0;
    else if (seen_q != 4'hf)  seen_q <= seen_q + 4'd1;
  end

  always @(posedge clk_i) begin
    if (!rst_ni) a_r6_reset_quiet: assert (clean_o == '0) else $error("R6 clean_o not zero in reset");
  end

  a_r1_bypass_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q >= 4'(SYNC_STAGES + 1) && !filt_en_i) |-> clean_o == $past(raw_i, SYNC_STAGES));

  a_r8_limit_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q >= 4'(SYNC_STAGES + 2) && filt_en_i && $past(filt_en_i)) |-> $stable(lim_i));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    // R2/R9: a filtered flip must follow at least two matching samples
    a_r2_flip_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (seen_q >= 4'(SYNC_STAGES + 6) && filt_en_i && $past(filt_en_i) && $past(filt_en_i, 2)
       && clean_o[c] != $past(clean_o[c]))
      |-> (clean_o[c] == $past(raw_i[c], SYNC_STAGES + 1)
           && clean_o[c] == $past(raw_i[c], SYNC_STAGES + 2)));
  end
endmodule

bind enc_spike_filter enc_flt_chk #(
  .NUM_CH(NUM_CH), .CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .raw_i    (raw_i),
  .filt_en_i(filt_en_i),
  .clean_o  (clean_o),
  .lim_i    (lim_q)
);

// File: tb/enc_spike_filter_test.sv
module enc_spike_filter_test;
  localparam int unsigned NC = 3;
  localparam int unsigned CW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NC-1:0] raw;
  logic          fen;
  logic [CW-1:0] maxc;
  logic [NC-1:0] clean;

  int cyc = 0;
  int checks = 0;
  int fails = 0;

  typedef struct {
    int            at;
    logic [NC-1:0] mask;
    logic [NC-1:0] val;
    string         tag;
  } exp_t;

  exp_t sbq[$];
  exp_t e;

  enc_spike_filter #(.NUM_CH(NC), .CNT_W(CW), .SYNC_STAGES(2)) uut (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .raw_i    (raw),
    .filt_en_i(fen),
    .max_cnt_i(maxc),
    .clean_o  (clean)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // monitor: pop every expectation due this cycle
  always @(negedge clk) begin
    while (sbq.size() > 0 && sbq[0].at <= cyc) begin
      e = sbq.pop_front();
      checks++;
      if (e.at < cyc || (clean & e.mask) != (e.val & e.mask)) begin
        fails++;
        $display("FAIL %s cycle %0d actual %b expected %b (mask %b)",
                 e.tag, e.at, clean & e.mask, e.val & e.mask, e.mask);
      end
    end
  end

  task automatic expect_at(int at, logic [NC-1:0] mask, logic [NC-1:0] val, string tag);
    exp_t x;
    x.at = at; x.mask = mask; x.val = val; x.tag = tag;
    sbq.push_back(x);
  endtask

  task automatic tick(int k);
    repeat (k) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog R1..R9 run: actual still running expected finished");
    summary();
    $finish;
  end

  initial begin
    int n;
    rst_n = 1'b0; raw = 3'b101; fen = 1'b1; maxc = 8'd5;
    expect_at(2, 3'b111, 3'b000, "R6 in reset");
    tick(4);
    rst_n = 1'b1; n = cyc;
    expect_at(n + 1, 3'b111, 3'b000, "R6 sync fill");
    expect_at(n + 2, 3'b111, 3'b101, "R6 first level");
    expect_at(n + 3, 3'b111, 3'b101, "R6 hold");
    expect_at(n + 12, 3'b111, 3'b101, "R6 no spurious edge");
    tick(14);

    // limit 5: accept at 7 cycles
    raw = 3'b100; n = cyc;
    expect_at(n + 8, 3'b001, 3'b001, "R2 before flip");
    expect_at(n + 9, 3'b001, 3'b000, "R2 flip");
    tick(12);

    // ch1 pulse of 6 (rejected) while ch0 rises (accepted)
    raw = 3'b111; n = cyc;
    expect_at(n + 8, 3'b010, 3'b000, "R3 short pulse");
    expect_at(n + 8, 3'b001, 3'b000, "R4 ch0 before flip");
    expect_at(n + 9, 3'b010, 3'b000, "R3 short pulse");
    expect_at(n + 9, 3'b001, 3'b001, "R4 ch0 flip");
    expect_at(n + 12, 3'b010, 3'b000, "R3 after pulse");
    tick(6);
    raw = 3'b101;
    tick(10);

    // pulse train 5 high / 1 low
    n = cyc;
    expect_at(n + 6, 3'b010, 3'b000, "R5 train");
    expect_at(n + 12, 3'b010, 3'b000, "R5 train");
    expect_at(n + 18, 3'b010, 3'b000, "R5 train");
    expect_at(n + 24, 3'b010, 3'b000, "R5 train");
    expect_at(n + 28, 3'b010, 3'b000, "R5 train end");
    for (int k = 0; k < 4; k++) begin
      raw = 3'b111; tick(5);
      raw = 3'b101; tick(1);
    end
    tick(6);

    // enable toggles with steady inputs
    fen = 1'b0; n = cyc;
    expect_at(n + 1, 3'b111, 3'b101, "R7 disable");
    expect_at(n + 3, 3'b111, 3'b101, "R7 disable");
    tick(4);
    fen = 1'b1; n = cyc;
    expect_at(n + 1, 3'b111, 3'b101, "R7 enable");
    expect_at(n + 2, 3'b111, 3'b101, "R7 enable");
    tick(3);

    // limit 0
    fen = 1'b0; maxc = 8'd0; tick(2);
    fen = 1'b1; tick(2);
    raw = 3'b100; n = cyc;
    expect_at(n + 3, 3'b001, 3'b001, "R9 1-cycle rejected");
    expect_at(n + 4, 3'b001, 3'b001, "R9 1-cycle rejected");
    expect_at(n + 6, 3'b001, 3'b001, "R9 1-cycle rejected");
    tick(1); raw = 3'b101; tick(8);
    raw = 3'b100; n = cyc;
    expect_at(n + 3, 3'b001, 3'b001, "R9 2-cycle before");
    expect_at(n + 4, 3'b001, 3'b000, "R9 2-cycle accepted");
    expect_at(n + 5, 3'b001, 3'b000, "R9 2-cycle held");
    expect_at(n + 6, 3'b001, 3'b001, "R9 return");
    tick(2); raw = 3'b101; tick(10);

    // limit changes while enabled are ignored
    maxc = 8'd20; tick(2);
    raw = 3'b100; n = cyc;
    expect_at(n + 4, 3'b001, 3'b000, "R8 limit kept at 0");
    expect_at(n + 6, 3'b001, 3'b001, "R8 limit kept at 0");
    tick(2); raw = 3'b101; tick(10);
    fen = 1'b0; tick(2);
    fen = 1'b1; tick(2);
    raw = 3'b100; n = cyc;
    expect_at(n + 4, 3'b001, 3'b001, "R8 new limit 20 rejects");
    expect_at(n + 6, 3'b001, 3'b001, "R8 new limit 20 rejects");
    expect_at(n + 10, 3'b001, 3'b001, "R8 new limit 20 rejects");
    tick(2); raw = 3'b101; tick(12);

    // bypass
    fen = 1'b0; tick(3);
    raw = 3'b100; n = cyc;
    expect_at(n + 1, 3'b001, 3'b001, "R1 before");
    expect_at(n + 2, 3'b001, 3'b000, "R1 pulse passes");
    expect_at(n + 3, 3'b001, 3'b001, "R1 pulse ends");
    tick(1); raw = 3'b101; tick(6);

    // all-ones limit
    maxc = 8'd255; tick(2);
    fen = 1'b1; tick(2);
    raw = 3'b001; n = cyc;
    expect_at(n + 258, 3'b100, 3'b100, "R3 256-cycle rejected at max");
    expect_at(n + 262, 3'b100, 3'b100, "R3 256-cycle rejected at max");
    tick(256); raw = 3'b101; tick(10);
    raw = 3'b001; n = cyc;
    expect_at(n + 258, 3'b100, 3'b100, "R2 max before flip");
    expect_at(n + 259, 3'b100, 3'b000, "R2 max flip");
    tick(264);

    if (sbq.size() != 0) begin
      fails++;
      $display("FAIL R1..R9 queue actual %0d left expected 0", sbq.size());
    end
    summary();
    $finish;
  end
endmodule